// File: doc/BRIEF.md
# Routed Level Interrupt Controller

This block gathers a set of level-sensitive interrupt inputs from peripherals and turns them into a small vector of interrupt request lines for a processor. Software turns individual sources on through an enable register. It can look at the raw input levels through a read-only status register. It chooses, for every source, which processor line that source drives by writing a 4-bit line number into a routing field.

A processor line is high while at least one source meets all three of these conditions: the source is enabled, its input is high, and its routing field holds that line's number. The output follows the inputs and the registered settings combinationally. There are no edge detectors, no priority logic and no vector generation. The dispatcher in software reads the enable and status registers and decides which source to service.

The register port is synchronous. A write takes effect at the clock edge where `reg_we` is high. Read data for the address presented at an edge appears on `reg_rdata` after that edge. It carries the register contents as they were before any write at that same edge.

Top module: `routed_irq_ctrl`

## Requirements
- R1: While reset is low, and directly after it is released, the enable register and all routing registers hold zero. `cpu_irq` is all zeros and `reg_rdata` is zero.
- R2: The enable register is at byte offset 0x00. Bit n set to 1 enables source n. All 32 bits read back exactly as last written.
- R3: The status register is at byte offset 0x04. A read returns `src_irq` as sampled at the read edge. A write to it changes no register.
- R4: The routing registers are at 0x08, 0x0C, 0x10 and 0x14. Source n uses the register at 0x08 + 4*(n/8), bits (n mod 8)*4 + 3 down to (n mod 8)*4. Each routing register reads back exactly what was last written.
- R5: `cpu_irq[k]` is 1 exactly when some source n has enable bit 1, input 1 and routing field equal to k. The output changes in the same cycle as `src_irq` and in the cycle after an enable or routing write.
- R6: A routing field of 0 leaves its source unrouted. `cpu_irq[0]` is always 0.
- R7: A routing field value of N_CPU or above (with the default of 8 lines: 8 to 15) drives no output line.
- R8: Only the six word-aligned offsets 0x00 to 0x14 are mapped. A read of any other byte address returns zero, and a write there changes no register.
- R9: Several sources routed to one line combine as an OR. The line stays high until the last contributing source is either disabled or drops its input.
- R10: A read data value is valid in the cycle after its address is presented. On a read of an address that is written at the same edge, `reg_rdata` shows the value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W (8) | Byte address of the register access |
| reg_we | input | 1 | Write strobe, sampled at the rising edge |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Read data for the address of the previous cycle |
| src_irq | input | N_SRC (32) | Level interrupt inputs from peripherals |
| cpu_irq | output | N_CPU (8) | Interrupt request lines toward the processor |

## Verification
The bench targets routing fields at their extremes. With field zero, a decoder that drove line 0 would raise `cpu_irq[0]`. With values above the last line, a truncated compare would alias the source onto a low line. It writes to the status register and to unmapped or misaligned addresses, then reads every register back. A decoder that ignores the low address bits or the read-only rule would corrupt the enable or routing state. It also stacks several sources onto one line and removes them one at a time, and reads registers in the same cycle they are written. A design with a wrong field offset, a missing OR term or a read that returns post-write data would show a line mismatch or a read mismatch in that exact cycle.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  // Which register a byte address selects
  typedef enum logic [1:0] {
    SEL_ENABLE = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_ROUTE  = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  // Byte offsets of the register file
  localparam int unsigned OFS_ENABLE = 0;
  localparam int unsigned OFS_STATUS = 4;
  localparam int unsigned OFS_ROUTE0 = 8;

  // Bit position of source n's routing field inside the flattened routing bank
  function automatic int unsigned route_lsb(int unsigned n, int unsigned field_w,
                                            int unsigned per_reg, int unsigned data_w);
    return (n / per_reg) * data_w + (n % per_reg) * field_w;
  endfunction

  // Number of routing registers needed to hold one field per source
  function automatic int unsigned route_regs(int unsigned n_src, int unsigned per_reg);
    return (n_src + per_reg - 1) / per_reg;
  endfunction

  // Index width with a floor of one bit
  function automatic int unsigned idx_width(int unsigned count);
    return (count > 1) ? $clog2(count) : 1;
  endfunction

endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
  import irq_route_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned N_ROUTE = 4,
  parameter int unsigned IDX_W   = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic [IDX_W-1:0]  route_idx
);

  localparam int unsigned WORD_ENABLE = OFS_ENABLE / 4;
  localparam int unsigned WORD_STATUS = OFS_STATUS / 4;
  localparam int unsigned WORD_ROUTE0 = OFS_ROUTE0 / 4;

  logic        aligned;
  int unsigned word_i;

  assign aligned = (addr[1:0] == 2'b00);
  assign word_i  = 32'(addr[ADDR_W-1:2]);

  always_comb begin
    sel       = SEL_NONE;
    route_idx = '0;
    if (aligned) begin
      if (word_i == WORD_ENABLE) begin
        sel = SEL_ENABLE;
      end else if (word_i == WORD_STATUS) begin
        sel = SEL_STATUS;
      end else if (word_i >= WORD_ROUTE0 && word_i < WORD_ROUTE0 + N_ROUTE) begin
        sel       = SEL_ROUTE;
        route_idx = IDX_W'(word_i - WORD_ROUTE0);
      end
    end
  end

endmodule

// File: rtl/irq_regbank.sv
module irq_regbank #(
  parameter int unsigned N_SRC   = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned N_ROUTE = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      enable_wr,
  input  logic [N_ROUTE-1:0]        route_wr,
  input  logic [DATA_W-1:0]         wdata,
  output logic [N_SRC-1:0]          enable_q,
  output logic [N_ROUTE*DATA_W-1:0] route_flat
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= '0;
    end else if (enable_wr) begin
      enable_q <= wdata[N_SRC-1:0];
    end
  end

  for (genvar r = 0; r < N_ROUTE; r++) begin : g_route
    logic [DATA_W-1:0] route_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        route_q <= '0;
      end else if (route_wr[r]) begin
        route_q <= wdata;
      end
    end

    assign route_flat[r*DATA_W +: DATA_W] = route_q;
  end

endmodule

// File: rtl/irq_route_fan.sv
module irq_route_fan
  import irq_route_pkg::*;
#(
  parameter int unsigned N_SRC   = 32,
  parameter int unsigned N_CPU   = 8,
  parameter int unsigned FIELD_W = 4,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned N_ROUTE = 4
) (
  input  logic [N_SRC-1:0]          pending,
  input  logic [N_ROUTE*DATA_W-1:0] route_flat,
  output logic [N_CPU-1:0]          cpu_irq
);

  localparam int unsigned PER_REG = DATA_W / FIELD_W;

  // Line 0 is the "unrouted" code and never drives
  assign cpu_irq[0] = 1'b0;

  for (genvar k = 1; k < N_CPU; k++) begin : g_line
    logic hit;

    always_comb begin
      hit = 1'b0;
      for (int n = 0; n < N_SRC; n++) begin
        if (pending[n] &&
            route_flat[route_lsb(n, FIELD_W, PER_REG, DATA_W) +: FIELD_W] == FIELD_W'(k)) begin
          hit = 1'b1;
        end
      end
    end

    assign cpu_irq[k] = hit;
  end

endmodule

// File: rtl/routed_irq_ctrl.sv
module routed_irq_ctrl
  import irq_route_pkg::*;
#(
  parameter int unsigned N_SRC   = 32,
  parameter int unsigned N_CPU   = 8,
  parameter int unsigned FIELD_W = 4,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [N_SRC-1:0]  src_irq,
  output logic [N_CPU-1:0]  cpu_irq
);

  localparam int unsigned PER_REG    = DATA_W / FIELD_W;
  localparam int unsigned N_ROUTE    = route_regs(N_SRC, PER_REG);
  localparam int unsigned IDX_W      = idx_width(N_ROUTE);
  localparam int unsigned ROUTE_BITS = N_ROUTE * DATA_W;

  // Named internal events, used by the checker
  reg_sel_e                sel;
  logic [IDX_W-1:0]        route_idx;
  logic                    enable_wr;
  logic [N_ROUTE-1:0]      route_wr;
  logic                    sel_none;
  logic [N_SRC-1:0]        enable_q;
  logic [ROUTE_BITS-1:0]   route_flat;
  logic [N_SRC-1:0]        pending_vec;
  logic [DATA_W-1:0]       rd_next;
  logic [DATA_W-1:0]       rdata_q;

  irq_addr_decode #(
    .ADDR_W (ADDR_W),
    .N_ROUTE(N_ROUTE),
    .IDX_W  (IDX_W)
  ) u_decode (
    .addr     (reg_addr),
    .sel      (sel),
    .route_idx(route_idx)
  );

  assign enable_wr = reg_we && (sel == SEL_ENABLE);
  assign sel_none  = (sel == SEL_NONE);

  for (genvar r = 0; r < N_ROUTE; r++) begin : g_wr
    assign route_wr[r] = reg_we && (sel == SEL_ROUTE) && (route_idx == IDX_W'(r));
  end

  irq_regbank #(
    .N_SRC  (N_SRC),
    .DATA_W (DATA_W),
    .N_ROUTE(N_ROUTE)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable_wr (enable_wr),
    .route_wr  (route_wr),
    .wdata     (reg_wdata),
    .enable_q  (enable_q),
    .route_flat(route_flat)
  );

  assign pending_vec = enable_q & src_irq;

  irq_route_fan #(
    .N_SRC  (N_SRC),
    .N_CPU  (N_CPU),
    .FIELD_W(FIELD_W),
    .DATA_W (DATA_W),
    .N_ROUTE(N_ROUTE)
  ) u_fan (
    .pending   (pending_vec),
    .route_flat(route_flat),
    .cpu_irq   (cpu_irq)
  );

  // Read path: select before the edge, register at the edge
  always_comb begin
    rd_next = '0;
    unique case (sel)
      SEL_ENABLE: rd_next[N_SRC-1:0] = enable_q;
      SEL_STATUS: rd_next[N_SRC-1:0] = src_irq;
      SEL_ROUTE:  rd_next = route_flat[32'(route_idx) * DATA_W +: DATA_W];
      default:    rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= rd_next;
    end
  end

  assign reg_rdata = rdata_q;

endmodule

// File: rtl/irq_ctrl_checker.sv
module irq_ctrl_checker #(
  parameter int unsigned N_SRC      = 32,
  parameter int unsigned N_CPU      = 8,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned N_ROUTE    = 4,
  parameter int unsigned ROUTE_BITS = 128
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  reg_we,
  input logic [DATA_W-1:0]     reg_wdata,
  input logic [DATA_W-1:0]     reg_rdata,
  input logic [N_CPU-1:0]      cpu_irq,
  input logic [N_SRC-1:0]      enable_q,
  input logic [ROUTE_BITS-1:0] route_flat,
  input logic [N_SRC-1:0]      pending_vec,
  input logic                  enable_wr,
  input logic [N_ROUTE-1:0]    route_wr,
  input logic                  sel_none
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (enable_q == '0 && route_flat == '0 && cpu_irq == '0 && reg_rdata == '0));

  // R2
  enable_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enable_wr |=> enable_q == $past(reg_wdata[N_SRC-1:0]));

  // R3
  ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !enable_wr && route_wr == '0) |=> ($stable(enable_q) && $stable(route_flat)));

  // R5
  idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_vec == '0) |-> (cpu_irq == '0));

  // R6
  line_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_irq[0]);

  // R8
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_none |=> (reg_rdata == '0));

  // R4
  route_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(route_wr));

endmodule

bind routed_irq_ctrl irq_ctrl_checker #(
  .N_SRC     (N_SRC),
  .N_CPU     (N_CPU),
  .DATA_W    (DATA_W),
  .ADDR_W    (ADDR_W),
  .N_ROUTE   (N_ROUTE),
  .ROUTE_BITS(ROUTE_BITS)
) u_irq_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_we     (reg_we),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .cpu_irq    (cpu_irq),
  .enable_q   (enable_q),
  .route_flat (route_flat),
  .pending_vec(pending_vec),
  .enable_wr  (enable_wr),
  .route_wr   (route_wr),
  .sel_none   (sel_none)
);

// File: tb/test_routed_irq_ctrl.sv
`timescale 1ns/1ps
module test_routed_irq_ctrl;

  localparam int N_SRC  = 32;
  localparam int N_CPU  = 8;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              we = 1'b0;
  logic [DATA_W-1:0] wdata = '0;
  logic [N_SRC-1:0]  src = '0;
  wire  [DATA_W-1:0] rdata;
  wire  [N_CPU-1:0]  cpu;

  always #2 clk = ~clk;

  routed_irq_ctrl i_routed_irq_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_addr (addr),
    .reg_we   (we),
    .reg_wdata(wdata),
    .reg_rdata(rdata),
    .src_irq  (src),
    .cpu_irq  (cpu)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // Behavioural reference: enable word and one line number per source
  logic [31:0] m_en = '0;
  int          m_line [N_SRC];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] m_read(logic [7:0] a, logic [31:0] s);
    if (a == 8'h00) return m_en;
    if (a == 8'h04) return s;
    if (a >= 8'h08 && a <= 8'h14 && a[1:0] == 2'b00) begin
      logic [31:0] v = '0;
      int base = ((a - 8) / 4) * 8;
      for (int j = 0; j < 8; j++) v[j*4 +: 4] = 4'(m_line[base + j]);
      return v;
    end
    return '0;
  endfunction

  task automatic m_write(logic [7:0] a, logic [31:0] d);
    if (a == 8'h00) m_en = d;
    else if (a >= 8'h08 && a <= 8'h14 && a[1:0] == 2'b00) begin
      int base = ((a - 8) / 4) * 8;
      for (int j = 0; j < 8; j++) m_line[base + j] = int'(d[j*4 +: 4]);
    end
  endtask

  function automatic logic [31:0] m_cpu(logic [31:0] s);
    logic [31:0] o = '0;
    for (int n = 0; n < N_SRC; n++)
      if (m_en[n] && s[n] && m_line[n] >= 1 && m_line[n] < N_CPU) o[m_line[n]] = 1'b1;
    return o;
  endfunction

  // One bus cycle, starting and ending at a falling edge
  task automatic step(string tag, logic [7:0] a, logic w, logic [31:0] d, logic [31:0] s);
    logic [31:0] exp_rd;
    addr = a; we = w; wdata = d; src = s;
    #1;
    chk({tag, " line"}, 32'(cpu), m_cpu(s));
    exp_rd = m_read(a, s);
    if (w) m_write(a, d);
    @(posedge clk);
    @(negedge clk);
    chk({tag, " read"}, rdata, exp_rd);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(4 * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int n = 0; n < N_SRC; n++) m_line[n] = 0;
    repeat (3) @(negedge clk);
    // R1: outputs while reset is held
    src = '1;
    #1;
    chk("R1 reset line", 32'(cpu), '0);
    chk("R1 reset read", rdata, '0);
    @(negedge clk);
    rst_n = 1'b1;
    step("R1", 8'h00, 0, '0, '1);
    step("R1", 8'h08, 0, '0, '1);
    step("R1", 8'h14, 0, '0, '1);

    // R2: enable register patterns
    step("R2", 8'h00, 1, 32'hA5A5_0F0F, '0);
    step("R2", 8'h00, 0, '0, '0);
    step("R2", 8'h00, 1, 32'hFFFF_FFFF, '0);
    step("R2", 8'h00, 0, '0, '0);

    // R4: routing registers and field placement
    step("R4", 8'h08, 1, 32'h7654_3210, '0);
    step("R4", 8'h0C, 1, 32'h0123_4567, '0);
    step("R4", 8'h10, 1, 32'h1111_2222, '0);
    step("R4", 8'h14, 1, 32'h3333_4444, '0);
    step("R4", 8'h08, 0, '0, '0);
    step("R4", 8'h14, 0, '0, '0);
    // R4: source 9 (register 0x0C, bits 7:4) alone drives line 6
    step("R4", 8'h04, 0, '0, 32'h0000_0200);

    // R10: read returns the value from before a same-edge write
    step("R10", 8'h10, 1, 32'h5555_6666, '0);
    step("R10", 8'h10, 0, '0, '0);

    // R3: status reads and ignored writes
    step("R3", 8'h04, 0, '0, 32'hDEAD_BEEF);
    step("R3", 8'h04, 1, 32'h0000_0000, 32'h1234_5678);
    step("R3", 8'h00, 0, '0, 32'h1234_5678);
    step("R3", 8'h08, 0, '0, '0);

    // R6: field 0 leaves the source unrouted
    step("R6", 8'h08, 1, 32'h0000_0000, '0);
    step("R6", 8'h04, 0, '0, 32'h0000_00FF);

    // R7: field values beyond the last line drive nothing
    step("R7", 8'h08, 1, 32'hFEDC_BA98, '0);
    step("R7", 8'h04, 0, '0, 32'h0000_00FF);

    // R8: unmapped and misaligned accesses
    step("R8", 8'h18, 1, 32'hFFFF_FFFF, '0);
    step("R8", 8'h02, 1, 32'h0000_0000, '0);
    step("R8", 8'hFC, 1, 32'h0000_0000, '0);
    step("R8", 8'h09, 0, '0, '0);
    step("R8", 8'h00, 0, '0, '0);
    step("R8", 8'h08, 0, '0, '0);

    // R9: three sources stacked on line 3, removed one by one
    step("R9", 8'h08, 1, 32'h0000_0333, '0);
    step("R9", 8'h00, 1, 32'h0000_0007, 32'h0000_0007);
    step("R9", 8'h00, 1, 32'h0000_0006, 32'h0000_0007);
    step("R9", 8'h04, 0, '0, 32'h0000_0004);
    step("R9", 8'h00, 1, 32'h0000_0002, 32'h0000_0004);
    step("R9", 8'h04, 0, '0, '0);

    // R5: mixed traffic
    for (int i = 0; i < 60; i++) begin
      logic [7:0] a;
      case ($urandom % 4)
        0: a = 8'h00;
        1: a = 8'h04;
        default: a = 8'(8 + 4 * ($urandom % 4));
      endcase
      step("R5", a, 1'($urandom % 2), $urandom, $urandom);
    end
    for (int i = 0; i < 20; i++) step("R5", 8'h00, 0, '0, $urandom);

    finish_run();
  end

endmodule